// File: doc/BRIEF.md
# Linked Motion and Stillness Detector

This block takes a stream of signed three-axis acceleration samples, each marked by a valid strobe. From that stream it raises two kinds of one-cycle event: motion, when any selected axis swings past a motion threshold, and stillness, when every selected axis has stayed inside a quiet band for a set number of ticks from an external time base. Each axis has its own selection mask for each function. A register records which axes caused the most recent motion event.

In chained mode only one of the two detectors is armed at a time, and each event hands the arming to the other detector. With the sleep option also on, a stillness event sets a sleep flag and a later motion event clears it. The thresholds, the duration, the masks and the mode bits are plain configuration inputs, held steady by the surrounding logic.

Top module: `motion_watch`

## Requirements
- R1: An axis counts as moving when the magnitude of its two's-complement sample is strictly greater than `mot_thr`, and as loud for stillness when that magnitude is strictly greater than `still_thr`. The most negative code has magnitude 2^(SAMPLE_W-1).
- R2: When a valid sample has at least one axis that is both selected in `mot_en` and moving, and motion detection is armed, `mot_pulse` is high for exactly the one cycle after that sample. Unselected axes never cause the event, and `mot_en` = 0 never produces one.
- R3: On each motion event `mot_src` (bit 0 = x, bit 1 = y, bit 2 = z) takes the set of axes that were both selected and moving in that sample. An unselected axis therefore reads 0. Between events it holds its value.
- R4: While stillness is armed and `still_en` is nonzero, each `tick` raises a count of quiet ticks by one. The tick that brings the count to `still_time` raises `still_pulse` in the next cycle and restarts the count from zero. A `still_time` of 0 fires on every tick.
- R5: A valid sample with a loud axis selected in `still_en` sets the count back to zero, and this wins over a `tick` in the same cycle. Loud samples on unselected axes have no effect. With `still_en` = 0 stillness never fires.
- R6: With `chain` = 1 and both masks nonzero, exactly one detector is armed at a time. After reset, motion is armed. A motion event arms stillness, and a stillness event arms motion again.
- R7: With `chain` = 0, both detectors are armed at the same time and can fire independently.
- R8: With `chain` = 1 and `nap_en` = 1, a stillness event sets `asleep` and a motion event clears it. In every other setting `asleep` holds its value.
- R9: Synchronous reset (`rst` high) clears both pulses, `mot_src`, `asleep` and the tick count, and leaves motion armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_x | input | SAMPLE_W | Signed x sample |
| smp_y | input | SAMPLE_W | Signed y sample |
| smp_z | input | SAMPLE_W | Signed z sample |
| tick | input | 1 | Duration time base strobe |
| mot_en | input | 3 | Motion axis mask (bit 0 = x) |
| still_en | input | 3 | Stillness axis mask (bit 0 = x) |
| mot_thr | input | SAMPLE_W | Unsigned motion threshold |
| still_thr | input | SAMPLE_W | Unsigned quiet band limit |
| still_time | input | DUR_W | Stillness duration in ticks |
| chain | input | 1 | Chain the two detectors |
| nap_en | input | 1 | Enable sleep flag tracking |
| mot_pulse | output | 1 | Motion event pulse |
| still_pulse | output | 1 | Stillness event pulse |
| mot_src | output | 3 | Axes involved in last motion event |
| asleep | output | 1 | Sleep flag |

## Verification
The motion comparator is swept over every sample code against thresholds of 0, 1, a middle value, the two values around the most negative magnitude, and the maximum. This separates a strict compare from an inclusive one and exposes a wrong magnitude for the most negative code. All eight axis masks are applied to one sample that has a mix of moving and still axes. This shows an OR across the selected axes, and shows the source bits of unselected axes being cleared. Tick sequences with loud, quiet, unselected-loud and same-cycle loud samples tell apart a correct restart, a missing restart and an off-by-one duration. A chained run and an unchained run with the sleep option on and off separate the arming hand-off from concurrent operation.

// File: rtl/motion_pkg.sv
package motion_pkg;
  localparam int NAX = 3;

  // OR across axes of an enable mask applied to a per-axis flag vector
  function automatic logic any_sel(input logic [NAX-1:0] en, input logic [NAX-1:0] flag);
    return |(en & flag);
  endfunction
endpackage

// File: rtl/motion_axis_cmp.sv
module motion_axis_cmp #(
  parameter int SAMPLE_W = 8
) (
  input  logic signed [SAMPLE_W-1:0] smp,
  input  logic        [SAMPLE_W-1:0] mot_thr,
  input  logic        [SAMPLE_W-1:0] still_thr,
  output logic                       over_mot,
  output logic                       over_still
);
  // magnitude of a two's complement value, unsigned, same width
  function automatic logic [SAMPLE_W-1:0] mag_of(input logic signed [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] raw;
    raw = s;
    return s[SAMPLE_W-1] ? (~raw + 1'b1) : raw;
  endfunction

  logic [SAMPLE_W-1:0] mag;

  always_comb begin
    mag        = mag_of(smp);
    over_mot   = mag > mot_thr;
    over_still = mag > still_thr;
  end
endmodule

// File: rtl/motion_still_timer.sv
module motion_still_timer #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             armed,
  input  logic             loud,
  input  logic             tick,
  input  logic [DUR_W-1:0] limit,
  output logic             fire
);
  logic [DUR_W-1:0] cnt;
  logic [DUR_W:0]   nxt;

  always_comb begin
    nxt  = {1'b0, cnt} + 1'b1;
    fire = armed && !loud && tick && (nxt >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst || !armed || loud) cnt <= '0;
    else if (tick) cnt <= fire ? '0 : nxt[DUR_W-1:0];
  end
endmodule

// File: rtl/motion_link_ctl.sv
module motion_link_ctl (
  input  logic clk,
  input  logic rst,
  input  logic chain,
  input  logic nap_en,
  input  logic both_sel,
  input  logic mot_evt,
  input  logic still_evt,
  output logic mot_armed,
  output logic still_armed,
  output logic want_still,
  output logic asleep
);
  logic linked;

  always_comb begin
    linked      = chain && both_sel;
    mot_armed   = !linked || !want_still;
    still_armed = !linked || want_still;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      want_still <= 1'b0;
      asleep     <= 1'b0;
    end else begin
      if (linked) begin
        if (mot_evt) want_still <= 1'b1;
        else if (still_evt) want_still <= 1'b0;
      end
      if (chain && nap_en) begin
        if (still_evt) asleep <= 1'b1;
        else if (mot_evt) asleep <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/motion_watch.sv
module motion_watch
  import motion_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int DUR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_x,
  input  logic signed [SAMPLE_W-1:0] smp_y,
  input  logic signed [SAMPLE_W-1:0] smp_z,
  input  logic                       tick,
  input  logic [2:0]                 mot_en,
  input  logic [2:0]                 still_en,
  input  logic [SAMPLE_W-1:0]        mot_thr,
  input  logic [SAMPLE_W-1:0]        still_thr,
  input  logic [DUR_W-1:0]           still_time,
  input  logic                       chain,
  input  logic                       nap_en,
  output logic                       mot_pulse,
  output logic                       still_pulse,
  output logic [2:0]                 mot_src,
  output logic                       asleep
);
  logic signed [SAMPLE_W-1:0] axis_smp [NAX];
  logic [NAX-1:0] over_mot, over_still, mot_hits;
  logic mot_evt, still_evt, still_loud;
  logic mot_armed, still_armed, want_still;

  assign axis_smp[0] = smp_x;
  assign axis_smp[1] = smp_y;
  assign axis_smp[2] = smp_z;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    motion_axis_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
      .smp       (axis_smp[a]),
      .mot_thr   (mot_thr),
      .still_thr (still_thr),
      .over_mot  (over_mot[a]),
      .over_still(over_still[a])
    );
  end

  always_comb begin
    mot_hits   = mot_en & over_mot;
    mot_evt    = smp_valid && mot_armed && (|mot_hits);
    still_loud = smp_valid && any_sel(still_en, over_still);
  end

  motion_still_timer #(.DUR_W(DUR_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .armed(still_armed && (|still_en)),
    .loud (still_loud),
    .tick (tick),
    .limit(still_time),
    .fire (still_evt)
  );

  motion_link_ctl u_link (
    .clk        (clk),
    .rst        (rst),
    .chain      (chain),
    .nap_en     (nap_en),
    .both_sel   ((|mot_en) && (|still_en)),
    .mot_evt    (mot_evt),
    .still_evt  (still_evt),
    .mot_armed  (mot_armed),
    .still_armed(still_armed),
    .want_still (want_still),
    .asleep     (asleep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mot_pulse   <= 1'b0;
      still_pulse <= 1'b0;
      mot_src     <= '0;
    end else begin
      mot_pulse   <= mot_evt;
      still_pulse <= still_evt;
      if (mot_evt) mot_src <= mot_hits;
    end
  end
endmodule

// File: rtl/motion_watch_chk.sv
module motion_watch_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mot_en,
  input logic [2:0] still_en,
  input logic       chain,
  input logic       nap_en,
  input logic       tick,
  input logic       mot_pulse,
  input logic       still_pulse,
  input logic [2:0] mot_src,
  input logic       asleep,
  input logic       want_still
);
  // R3
  src_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    mot_pulse |-> (mot_src != 3'b000));
  // R3
  src_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
    mot_pulse |-> ((mot_src & ~$past(mot_en)) == 3'b000));
  // R2
  mot_masked_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mot_en == 3'b000) |=> !mot_pulse);
  // R5
  still_masked_off_chk: assert property (@(posedge clk) disable iff (rst)
    (still_en == 3'b000) |=> !still_pulse);
  // R4
  still_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    still_pulse |-> $past(tick));
  // R6
  chain_mot_held_chk: assert property (@(posedge clk) disable iff (rst)
    (chain && (mot_en != 3'b000) && (still_en != 3'b000) && want_still) |=> !mot_pulse);
  // R6
  chain_still_held_chk: assert property (@(posedge clk) disable iff (rst)
    (chain && (mot_en != 3'b000) && (still_en != 3'b000) && !want_still) |=> !still_pulse);
  // R8
  nap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(chain && nap_en) |=> $stable(asleep));
  // R8
  nap_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> still_pulse);
endmodule

bind motion_watch motion_watch_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .mot_en     (mot_en),
  .still_en   (still_en),
  .chain      (chain),
  .nap_en     (nap_en),
  .tick       (tick),
  .mot_pulse  (mot_pulse),
  .still_pulse(still_pulse),
  .mot_src    (mot_src),
  .asleep     (asleep),
  .want_still (want_still)
);

// File: tb/test_motion_watch.sv
`timescale 1ns/1ps
module test_motion_watch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [7:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic tick = 1'b0;
  logic [2:0] mot_en = '0, still_en = '0;
  logic [7:0] mot_thr = '0, still_thr = '0, still_time = '0;
  logic chain = 1'b0, nap_en = 1'b0;
  logic mot_pulse, still_pulse, asleep;
  logic [2:0] mot_src;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  motion_watch i_motion_watch (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .tick(tick),
    .mot_en(mot_en), .still_en(still_en), .mot_thr(mot_thr),
    .still_thr(still_thr), .still_time(still_time), .chain(chain),
    .nap_en(nap_en), .mot_pulse(mot_pulse), .still_pulse(still_pulse),
    .mot_src(mot_src), .asleep(asleep)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // drive one sample; outputs are checked at the following negedge
  task automatic send(input int x, input int y, input int z, input bit with_tick);
    @(negedge clk);
    smp_x = 8'(x); smp_y = 8'(y); smp_z = 8'(z);
    smp_valid = 1'b1; tick = with_tick;
    @(negedge clk);
    smp_valid = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int thr_set [6] = '{0, 1, 37, 127, 128, 255};
    int exp_src;
    int ov;

    // R9 reset state
    @(negedge clk); @(negedge clk);
    chk("R9 mot_pulse", mot_pulse, 0);
    chk("R9 still_pulse", still_pulse, 0);
    chk("R9 mot_src", mot_src, 0);
    chk("R9 asleep", asleep, 0);
    rst = 1'b0;

    // R1/R2/R3 sweep of every x code over several thresholds
    mot_en = 3'b001; still_en = 3'b000;
    exp_src = 0;
    foreach (thr_set[t]) begin
      mot_thr = 8'(thr_set[t]);
      for (int v = -128; v < 128; v++) begin
        send(v, 0, 0, 1'b0);
        ov = (absv(v) > thr_set[t]) ? 1 : 0;
        chk($sformatf("R1 R2 x=%0d thr=%0d", v, thr_set[t]), mot_pulse, ov);
        if (ov == 1) exp_src = 1;
        chk("R3 src after sweep sample", mot_src, exp_src);
      end
    end

    // R2/R3 every axis mask on one mixed sample: x and z move, y does not
    mot_thr = 8'd50;
    for (int m = 0; m < 8; m++) begin
      mot_en = 3'(m);
      send(100, -5, -90, 1'b0);
      ov = m & 5;
      chk($sformatf("R2 mask=%0d pulse", m), mot_pulse, (ov != 0) ? 1 : 0);
      if (ov != 0) exp_src = ov;
      chk($sformatf("R3 mask=%0d src", m), mot_src, exp_src);
    end
    mot_en = 3'b001;
    send(100, -5, -90, 1'b0);
    chk("R3 unselected z bit cleared", mot_src, 1);
    send(0, 0, 0, 1'b0);
    chk("R3 src held without event", mot_src, 1);

    // R4/R5 stillness timing, unchained
    mot_en = 3'b000; still_en = 3'b111; still_thr = 8'd10; still_time = 8'd3;
    do_reset();
    for (int k = 1; k <= 6; k++) begin
      pulse_tick();
      chk($sformatf("R4 tick %0d", k), still_pulse, (k % 3 == 0) ? 1 : 0);
    end
    pulse_tick(); pulse_tick();
    send(11, 0, 0, 1'b0);
    chk("R5 loud sample no pulse", still_pulse, 0);
    pulse_tick(); chk("R5 restart tick1", still_pulse, 0);
    pulse_tick(); chk("R5 restart tick2", still_pulse, 0);
    pulse_tick(); chk("R5 restart tick3", still_pulse, 1);
    pulse_tick();
    send(10, -10, 0, 1'b0);
    pulse_tick(); chk("R5 quiet sample keeps count", still_pulse, 0);
    pulse_tick(); chk("R5 quiet sample third tick", still_pulse, 1);
    still_en = 3'b110;
    pulse_tick();
    send(100, 0, 0, 1'b0);
    pulse_tick(); chk("R5 unselected loud ignored a", still_pulse, 0);
    pulse_tick(); chk("R5 unselected loud ignored b", still_pulse, 1);
    still_en = 3'b111;
    pulse_tick(); pulse_tick();
    send(0, 0, -11, 1'b1);
    chk("R5 loud wins over tick", still_pulse, 0);
    pulse_tick(); chk("R5 after same-cycle tick1", still_pulse, 0);
    pulse_tick(); chk("R5 after same-cycle tick2", still_pulse, 0);
    pulse_tick(); chk("R5 after same-cycle tick3", still_pulse, 1);
    still_time = 8'd0;
    pulse_tick(); chk("R4 zero duration a", still_pulse, 1);
    pulse_tick(); chk("R4 zero duration b", still_pulse, 1);
    still_en = 3'b000;
    for (int k = 0; k < 4; k++) begin
      pulse_tick(); chk("R5 empty mask never fires", still_pulse, 0);
    end

    // R6/R8 chained with sleep
    mot_en = 3'b111; still_en = 3'b111; mot_thr = 8'd50; still_thr = 8'd10;
    still_time = 8'd2; chain = 1'b1; nap_en = 1'b1;
    do_reset();
    for (int k = 0; k < 3; k++) begin
      pulse_tick(); chk("R6 stillness disarmed after reset", still_pulse, 0);
    end
    send(100, 0, 0, 1'b0);
    chk("R6 motion armed after reset", mot_pulse, 1);
    chk("R3 chained src", mot_src, 1);
    chk("R8 asleep still low", asleep, 0);
    send(0, -100, 0, 1'b0);
    chk("R6 motion disarmed", mot_pulse, 0);
    chk("R3 src held", mot_src, 1);
    pulse_tick(); chk("R6 still tick1", still_pulse, 0);
    pulse_tick(); chk("R6 still tick2", still_pulse, 1);
    chk("R8 asleep set", asleep, 1);
    for (int k = 0; k < 3; k++) begin
      pulse_tick(); chk("R6 stillness disarmed again", still_pulse, 0);
    end
    send(0, 0, 60, 1'b0);
    chk("R6 motion rearmed", mot_pulse, 1);
    chk("R3 z source", mot_src, 4);
    chk("R8 asleep cleared", asleep, 0);
    nap_en = 1'b0;
    pulse_tick(); pulse_tick();
    chk("R8 still fires without nap", still_pulse, 1);
    chk("R8 asleep holds without nap", asleep, 0);

    // R7/R8 unchained: concurrent, sleep flag untouched
    chain = 1'b0; nap_en = 1'b1;
    do_reset();
    send(100, 0, 0, 1'b0); chk("R7 motion 1", mot_pulse, 1);
    send(0, 100, 0, 1'b0); chk("R7 motion 2", mot_pulse, 1);
    pulse_tick(); pulse_tick();
    chk("R7 stillness concurrent", still_pulse, 1);
    chk("R8 asleep unchanged unchained", asleep, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule